// File: doc/BRIEF.md
# Configurable Input Capture Cell

This block is the input half of a programmable pin cell. It takes a bus of pad bits and hands them to the fabric in one of five ways, chosen when the cell is built:

- a plain combinational path;
- a transparent hold latch;
- an edge-triggered register;
- a register followed by a hold latch;
- a dual-edge capture that presents two samples per clock period on two separate outputs.

A clock enable gates every register in the cell. A build-time polarity switch picks the primary capture edge: rising or falling.

In the latched variants a hold control freezes what the fabric sees. While hold is high, changes upstream of the latch do not reach the output. When hold drops, the latch becomes transparent again.

In the dual-edge variant both outputs update together on the primary edge. The second output carries the value the pad had at the secondary edge half a period earlier. This lets the fabric consume both samples in a single clock domain.

Top module: `io_in_cell`

## Requirements
- R1: With MODE = CAP_PASS, dout0 equals pad_i combinationally, with no clock involvement.
- R2: With MODE = CAP_LATCH, dout0 follows pad_i while hold is 0. While hold is 1, dout0 keeps the value pad_i had when hold rose, whatever pad_i does.
- R3: With MODE = CAP_REG, at every primary edge with ce = 1 and rst = 0, dout0 takes the value of pad_i sampled at that edge.
- R4: With MODE = CAP_REG_LATCH, the register keeps capturing pad_i while hold is 1, but dout0 stays at the register value present when hold rose. When hold falls, dout0 shows the current register value.
- R5: With MODE = CAP_DDR, at every primary edge with ce = 1, dout0 takes pad_i sampled at that edge. At the same edge, dout1 takes the pad_i value captured at the preceding secondary edge.
- R6: When ce = 0 at a clock edge, no register of the cell changes at that edge. This applies to both edges in CAP_DDR.
- R7: With NEG_EDGE = 1, the primary edge is the falling edge of clk and the secondary edge is the rising edge. With NEG_EDGE = 0, the roles are swapped back.
- R8: In every mode other than CAP_DDR, dout1 is constantly 0.
- R9: rst is synchronous and active high. Each register clears to 0 on its own capture edge while rst = 1, with priority over ce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input capture clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for every register in the cell |
| hold | input | 1 | Freezes the latch output while 1 (latched modes) |
| pad_i | input | WIDTH | Bits arriving from the pads |
| dout0 | output | WIDTH | Primary data to the fabric |
| dout1 | output | WIDTH | Secondary-edge data (dual-edge mode), else 0 |

## Verification
The bench builds six copies of the cell with a four-bit bus, one per capture mode with the rising edge as primary, plus a registered copy with NEG_EDGE = 1. All copies share one stimulus stream, so a single sequence of pad values, enable gaps and hold windows can be compared across every mode at once. The falling-edge copy makes the edge swap observable: its output must track the values present at falling edges while its rising-edge twin tracks the other half period. The four-bit width lets distinct patterns on each bit expose bit swaps or stuck bits.

// File: rtl/io_in_pkg.sv
package io_in_pkg;

    typedef enum logic [2:0] {
        CAP_PASS      = 3'd0,
        CAP_LATCH     = 3'd1,
        CAP_REG       = 3'd2,
        CAP_REG_LATCH = 3'd3,
        CAP_DDR       = 3'd4
    } cap_mode_e;

    // One bit of a dual-edge capture: primary-edge and secondary-edge samples.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    function automatic bit mode_has_reg(cap_mode_e m);
        return (m == CAP_REG) || (m == CAP_REG_LATCH);
    endfunction

    function automatic bit mode_has_latch(cap_mode_e m);
        return (m == CAP_LATCH) || (m == CAP_REG_LATCH);
    endfunction

    function automatic bit mode_is_ddr(cap_mode_e m);
        return m == CAP_DDR;
    endfunction

endpackage

// File: rtl/io_in_edge_reg.sv
module io_in_edge_reg #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (ce) begin
            q <= d;
        end
    end

endmodule

// File: rtl/io_in_hold_latch.sv
module io_in_hold_latch #(
    parameter int WIDTH = 1
) (
    input  logic             hold,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Transparent while hold is low, opaque while high.
    always_latch begin
        if (!hold) begin
            q <= d;
        end
    end

endmodule

// File: rtl/io_in_ddr.sv
module io_in_ddr
    import io_in_pkg::*;
#(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q_rise,
    output logic [WIDTH-1:0] q_fall
);

    edge_pair_t [WIDTH-1:0] out_q;
    logic       [WIDTH-1:0] fall_stage;

    // Secondary-edge sample; its reset is taken on its own edge.
    always_ff @(negedge clk) begin
        if (rst) begin
            fall_stage <= '0;
        end else if (ce) begin
            fall_stage <= d;
        end
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        // Both halves move together on the primary edge.
        always_ff @(posedge clk) begin
            if (rst) begin
                out_q[b] <= '0;
            end else if (ce) begin
                out_q[b].rise <= d[b];
                out_q[b].fall <= fall_stage[b];
            end
        end
        assign q_rise[b] = out_q[b].rise;
        assign q_fall[b] = out_q[b].fall;
    end

endmodule

// File: rtl/io_in_cell.sv
module io_in_cell
    import io_in_pkg::*;
#(
    parameter int        WIDTH    = 1,
    parameter cap_mode_e MODE     = CAP_DDR,
    parameter bit        NEG_EDGE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             hold,
    input  logic [WIDTH-1:0] pad_i,
    output logic [WIDTH-1:0] dout0,
    output logic [WIDTH-1:0] dout1
);

    localparam logic EDGE_FLIP = NEG_EDGE;

    logic pclk;
    logic cfg_unused;

    // Primary edge is always the rising edge of pclk.
    assign pclk       = clk ^ EDGE_FLIP;
    assign cfg_unused = &{1'b0, pclk, rst, ce, hold};

    if (mode_is_ddr(MODE)) begin : g_ddr
        io_in_ddr #(.WIDTH(WIDTH)) u_ddr (
            .clk    (pclk),
            .rst    (rst),
            .ce     (ce),
            .d      (pad_i),
            .q_rise (dout0),
            .q_fall (dout1)
        );
    end else begin : g_sdr
        logic [WIDTH-1:0] stage_q;

        if (mode_has_reg(MODE)) begin : g_reg
            io_in_edge_reg #(.WIDTH(WIDTH)) u_reg (
                .clk (pclk),
                .rst (rst),
                .ce  (ce),
                .d   (pad_i),
                .q   (stage_q)
            );
        end else begin : g_noreg
            assign stage_q = pad_i;
        end

        if (mode_has_latch(MODE)) begin : g_lat
            io_in_hold_latch #(.WIDTH(WIDTH)) u_lat (
                .hold (hold),
                .d    (stage_q),
                .q    (dout0)
            );
        end else begin : g_nolat
            assign dout0 = stage_q;
        end

        assign dout1 = '0;
    end

endmodule

// File: rtl/io_in_cell_chk.sv
module io_in_cell_chk
    import io_in_pkg::*;
#(
    parameter int        WIDTH    = 1,
    parameter cap_mode_e MODE     = CAP_DDR,
    parameter bit        NEG_EDGE = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic             ce,
    input logic             hold,
    input logic [WIDTH-1:0] pad_i,
    input logic [WIDTH-1:0] dout0,
    input logic [WIDTH-1:0] dout1
);

    localparam logic EDGE_FLIP = NEG_EDGE;

    logic pclk;
    logic chk_unused;
    assign pclk       = clk ^ EDGE_FLIP;
    assign chk_unused = &{1'b0, hold, ce, rst, pad_i, dout0, dout1};

    if (MODE == CAP_REG || MODE == CAP_DDR) begin : g_edge
        // R3, R5, R7: enabled primary edge loads the pad sample
        assert_primary_load_R3: assert property (@(posedge pclk) disable iff (rst)
            ce |=> dout0 == $past(pad_i))
            else $error("primary-edge load mismatch");

        // R6: no update while disabled
        assert_ce_gate_R6: assert property (@(posedge pclk) disable iff (rst)
            !ce |=> $stable(dout0))
            else $error("dout0 changed with ce low");

        // R9: reset clears the output
        assert_reset_clear_R9: assert property (@(posedge pclk)
            rst |=> dout0 == '0)
            else $error("dout0 not cleared by reset");
    end

    if (MODE == CAP_DDR) begin : g_ddr
        // R6: secondary output also gated
        assert_ce_gate_fall_R6: assert property (@(posedge pclk) disable iff (rst)
            !ce |=> $stable(dout1))
            else $error("dout1 changed with ce low");
    end else begin : g_sdr
        // R8: secondary output is tied low
        assert_dout1_zero_R8: assert property (@(posedge clk)
            dout1 == '0)
            else $error("dout1 nonzero outside dual-edge mode");
    end

    if (MODE == CAP_LATCH) begin : g_lat
        // R2: held output does not move while hold stays high
        assert_hold_freeze_R2: assert property (@(posedge clk) disable iff (rst)
            (hold && $past(hold)) |-> $stable(dout0))
            else $error("latched output moved under hold");
    end

endmodule

bind io_in_cell io_in_cell_chk #(
    .WIDTH    (WIDTH),
    .MODE     (MODE),
    .NEG_EDGE (NEG_EDGE)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .ce    (ce),
    .hold  (hold),
    .pad_i (pad_i),
    .dout0 (dout0),
    .dout1 (dout1)
);

// File: tb/io_in_cell_tb_top.sv
`timescale 1ns/1ps
module io_in_cell_tb_top;
    import io_in_pkg::*;

    localparam int W = 4;

    typedef struct packed {
        logic [W-1:0] p;   // pad value across the primary edge
        logic [W-1:0] n;   // pad value across the following secondary edge
        logic         en;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{4'h1, 4'h2, 1'b1}, '{4'h4, 4'h8, 1'b1}, '{4'hF, 4'h0, 1'b1},
        '{4'hA, 4'h5, 1'b0}, '{4'h3, 4'hC, 1'b0}, '{4'h6, 4'h9, 1'b1},
        '{4'h0, 4'hF, 1'b1}, '{4'h7, 4'hE, 1'b0}, '{4'hB, 4'hD, 1'b1},
        '{4'h5, 4'hA, 1'b1}, '{4'hE, 4'h1, 1'b0}, '{4'h2, 4'h7, 1'b1}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ce = 1'b0;
    logic         hold = 1'b0;
    logic [W-1:0] pad = '0;

    logic [W-1:0] ddr0, ddr1, pas0, pas1, lat0, lat1, reg0, reg1, rl0, rl1, neg0, neg1;

    int  n_tests = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    io_in_cell #(.WIDTH(W), .MODE(CAP_DDR), .NEG_EDGE(1'b0)) dut_i (
        .clk(clk), .rst(rst), .ce(ce), .hold(hold), .pad_i(pad), .dout0(ddr0), .dout1(ddr1));
    io_in_cell #(.WIDTH(W), .MODE(CAP_PASS), .NEG_EDGE(1'b0)) dut_pass (
        .clk(clk), .rst(rst), .ce(ce), .hold(hold), .pad_i(pad), .dout0(pas0), .dout1(pas1));
    io_in_cell #(.WIDTH(W), .MODE(CAP_LATCH), .NEG_EDGE(1'b0)) dut_lat (
        .clk(clk), .rst(rst), .ce(ce), .hold(hold), .pad_i(pad), .dout0(lat0), .dout1(lat1));
    io_in_cell #(.WIDTH(W), .MODE(CAP_REG), .NEG_EDGE(1'b0)) dut_reg (
        .clk(clk), .rst(rst), .ce(ce), .hold(hold), .pad_i(pad), .dout0(reg0), .dout1(reg1));
    io_in_cell #(.WIDTH(W), .MODE(CAP_REG_LATCH), .NEG_EDGE(1'b0)) dut_rlat (
        .clk(clk), .rst(rst), .ce(ce), .hold(hold), .pad_i(pad), .dout0(rl0), .dout1(rl1));
    io_in_cell #(.WIDTH(W), .MODE(CAP_REG), .NEG_EDGE(1'b1)) dut_neg (
        .clk(clk), .rst(rst), .ce(ce), .hold(hold), .pad_i(pad), .dout0(neg0), .dout1(neg1));

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        logic [W-1:0] e0, e1, fall_m;
        e0 = '0; e1 = '0; fall_m = '0;

        // Reset state
        repeat (3) @(posedge clk);
        #2;
        chk("R9 ddr dout0 reset", ddr0, '0);
        chk("R9 ddr dout1 reset", ddr1, '0);
        chk("R9 reg reset", reg0, '0);
        chk("R9 reg+latch reset", rl0, '0);
        chk("R9 R7 negedge reg reset", neg0, '0);
        chk("R1 pass at reset", pas0, pad);
        @(negedge clk); #1 rst = 1'b0;

        // Table walk: all modes with hold low
        for (int k = 0; k < 12; k++) begin
            @(negedge clk); #1;
            pad = VECS[k].p;
            ce  = VECS[k].en;
            @(posedge clk); #1;
            pad = VECS[k].n;
            #1;
            if (VECS[k].en) begin
                e0 = VECS[k].p;
                e1 = fall_m;
            end
            chk("R5 R6 ddr dout0", ddr0, e0);
            chk("R5 R6 ddr dout1", ddr1, e1);
            chk("R3 R6 reg dout0", reg0, e0);
            chk("R4 reg+latch transparent", rl0, e0);
            chk("R7 R6 negedge reg dout0", neg0, fall_m);
            chk("R1 pass dout0", pas0, VECS[k].n);
            chk("R2 latch transparent", lat0, VECS[k].n);
            chk("R8 reg dout1 zero", reg1, '0);
            chk("R8 latch dout1 zero", lat1 | pas1 | rl1 | neg1, '0);
            if (VECS[k].en) fall_m = VECS[k].n;
        end

        // Hold behaviour in the two latched modes
        @(negedge clk); #1;
        pad = 4'h3; ce = 1'b1; hold = 1'b0;
        @(posedge clk); #2;
        chk("R4 reg+latch before hold", rl0, 4'h3);
        hold = 1'b1;
        #1;
        @(negedge clk); #1 pad = 4'hC;
        @(posedge clk); #2;
        chk("R3 reg keeps loading", reg0, 4'hC);
        chk("R4 reg+latch frozen", rl0, 4'h3);
        chk("R2 latch frozen", lat0, 4'h3);
        chk("R1 pass ignores hold", pas0, 4'hC);
        hold = 1'b0;
        #1;
        chk("R4 reg+latch released", rl0, 4'hC);
        chk("R2 latch released", lat0, 4'hC);

        // Mid-run reset
        @(negedge clk); #1 rst = 1'b1;
        @(posedge clk); #2;
        chk("R9 ddr dout0 mid reset", ddr0, '0);
        chk("R9 ddr dout1 mid reset", ddr1, '0);
        chk("R9 reg mid reset", reg0, '0);
        @(negedge clk); #2;
        chk("R9 R7 negedge reg mid reset", neg0, '0);
        #1 rst = 1'b0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule